// File: doc/BRIEF.md
# Halfword-Granule Instruction Fetch Sequencer

This block fetches a single instruction for a processor front end that mixes 16-bit compressed and 32-bit encodings. It works in 16-bit halfwords. For the first halfword at the requested PC it runs a pluggable extension check, which may reject the address or substitute another one. It then checks alignment, asks a translation port for a physical address, and reads the halfword through a 16-bit memory port. When that halfword is a full-length encoding, it repeats the extension check, translation and read for the halfword at PC+2. Each halfword is translated and checked on its own, so a fault is reported against the exact halfword address that caused it.

The result is a compressed instruction, a 32-bit instruction, a fetch error or an extension error. It comes with an exception code and a fault address, and it is marked by a one-cycle `res_valid` pulse. The extension check is a combinational hook. The translation port and the memory port use request/acknowledge handshakes, and their responses are sampled in the acknowledge cycle.

The control FSM has six states:
- `S_IDLE` accepts a request and runs the hook and the alignment check. It moves to `S_DONE` on an error, otherwise to `S_XLATE_LO`.
- `S_XLATE_LO` moves to `S_DONE` on a translation fault, otherwise to `S_READ_LO`.
- `S_READ_LO` moves to `S_DONE` on a memory fault, a compressed halfword or a rejection of PC+2 by the hook, otherwise to `S_XLATE_HI`.
- `S_XLATE_HI` moves to `S_DONE` on a fault, otherwise to `S_READ_HI`.
- `S_READ_HI` always moves to `S_DONE`.
- `S_DONE` presents the result and returns to `S_IDLE`.

Top module: `halfword_fetch_seq`

## Requirements
- R1: After synchronous active-high reset, `req_ready` is 1, and `res_valid`, `xl_req` and `mem_req` are 0.
- R2: A first halfword is compressed when its bits [1:0] are not 2'b11. Such a fetch ends with `res_kind`=0 (compressed), `res_instr`[15:0] equal to the halfword, `res_instr`[31:16]=0 and `res_code`=0. It performs exactly one memory read and no second extension check.
- R3: A full-length fetch ends with `res_kind`=1 and `res_instr` = {second halfword, first halfword}, the second halfword coming from PC+2. It performs two translations and two reads, `res_code` is 0 and `res_faddr` is the PC.
- R4: If the hook rejects the PC (`hook_ok`=0), the result is `res_kind`=3 (extension error), with `res_code`=`hook_ecode` and `res_faddr`=PC. No translation or read is issued.
- R5: The first translation uses the address the hook returns (`hook_xaddr`), not the PC. Every error raised on the first halfword reports the untransformed PC in `res_faddr`.
- R6: If the address returned by the hook has bit 0 set, or has bit 1 set while `cmp_en`=0, the result is `res_kind`=2 (fetch error) with `res_code`=`MISALIGN_CODE` (default 0) and `res_faddr`=PC. No translation is issued.
- R7: A translation fault (`xl_fault`) or a memory fault (`mem_fault`) on the first halfword gives `res_kind`=2, `res_code` equal to the port's code and `res_faddr`=PC.
- R8: The second halfword address PC+2 passes through the hook and is translated using the address the hook returns. A rejection there gives `res_kind`=3 with `res_faddr`=PC+2. A translation or memory fault there gives `res_kind`=2 with the port's code and `res_faddr`=PC+2.
- R9: `xl_req` stays high with a stable `xl_va` until `xl_ack`, and `mem_req` stays high with a stable `mem_pa` until `mem_ack`. The two requests are never high together.
- R10: `res_valid` is a single-cycle pulse that is never high together with `req_ready`. The cycle after the pulse, the block is back in `S_IDLE` with `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_en | input | 1 | Compressed encodings allowed (relaxes bit-1 alignment) |
| req_valid | input | 1 | Fetch request |
| req_pc | input | XLEN | PC to fetch |
| req_ready | output | 1 | High in S_IDLE; a request is taken when req_valid is also high |
| hook_valid | output | 1 | A hook result is being consumed this cycle |
| hook_va | output | XLEN | Halfword address presented to the extension hook |
| hook_ok | input | 1 | Hook accepts the address |
| hook_xaddr | input | XLEN | Address the hook returns for the fetch |
| hook_ecode | input | ECW | Hook error code when rejected |
| xl_req | output | 1 | Translation request |
| xl_va | output | XLEN | Address to translate |
| xl_ack | input | 1 | Translation response valid |
| xl_fault | input | 1 | Translation failed |
| xl_code | input | ECW | Translation fault code |
| xl_pa | input | XLEN | Translated address |
| mem_req | output | 1 | Halfword read request |
| mem_pa | output | XLEN | Read address |
| mem_ack | input | 1 | Read response valid |
| mem_fault | input | 1 | Read failed |
| mem_code | input | ECW | Read fault code |
| mem_data | input | 16 | Halfword read data |
| res_valid | output | 1 | One-cycle result pulse |
| res_kind | output | 2 | 0 compressed, 1 full, 2 fetch error, 3 extension error |
| res_instr | output | 32 | Instruction bits (0 on errors) |
| res_code | output | ECW | Exception code (0 on success) |
| res_faddr | output | XLEN | PC for success and first-halfword errors; PC+2 for second-halfword errors |

## Verification
The handshake assertions rely on the environment raising `xl_ack` and `mem_ack` only while the matching request is high, and on the hook answering combinationally in the same cycle. The bench responders derive each acknowledge from the live request, with one wait cycle, and drop it after a single cycle. They compute the hook, translation, fault and read-data responses purely from the presented address. The sweep covers:
- every PC offset within a word;
- both `cmp_en` values;
- three hook transforms: identity, flip bit 0, flip bit 1;
- both first-halfword encodings;
- every single fault site.

// File: rtl/hfs_pkg.sv
package hfs_pkg;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_XLATE_LO = 3'd1,
        S_READ_LO  = 3'd2,
        S_XLATE_HI = 3'd3,
        S_READ_HI  = 3'd4,
        S_DONE     = 3'd5
    } hfs_state_e;

    typedef enum logic [1:0] {
        RK_COMP = 2'd0,
        RK_FULL = 2'd1,
        RK_FERR = 2'd2,
        RK_XERR = 2'd3
    } hfs_kind_e;

endpackage

// File: rtl/hfs_align_chk.sv
module hfs_align_chk #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] addr,
    input  logic            cmp_en,
    output logic            misaligned
);
    // odd byte address never valid; bit 1 only valid with compressed support
    always_comb misaligned = addr[0] | (addr[1] & ~cmp_en);
endmodule

// File: rtl/hfs_hw_class.sv
module hfs_hw_class (
    input  logic [15:0] hw,
    output logic        is_cmp
);
    always_comb is_cmp = (hw[1:0] != 2'b11);
endmodule

// File: rtl/hfs_result_reg.sv
module hfs_result_reg
    import hfs_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int ECW  = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  hfs_kind_e       kind_d,
    input  logic [31:0]     instr_d,
    input  logic [ECW-1:0]  code_d,
    input  logic [XLEN-1:0] faddr_d,
    output hfs_kind_e       kind_q,
    output logic [31:0]     instr_q,
    output logic [ECW-1:0]  code_q,
    output logic [XLEN-1:0] faddr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= RK_COMP;
            instr_q <= '0;
            code_q  <= '0;
            faddr_q <= '0;
        end else if (load) begin
            kind_q  <= kind_d;
            instr_q <= instr_d;
            code_q  <= code_d;
            faddr_q <= faddr_d;
        end
    end
endmodule

// File: rtl/halfword_fetch_seq.sv
module halfword_fetch_seq
    import hfs_pkg::*;
#(
    parameter int XLEN          = 32,
    parameter int ECW           = 6,
    parameter int MISALIGN_CODE = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmp_en,
    input  logic            req_valid,
    input  logic [XLEN-1:0] req_pc,
    output logic            req_ready,
    output logic            hook_valid,
    output logic [XLEN-1:0] hook_va,
    input  logic            hook_ok,
    input  logic [XLEN-1:0] hook_xaddr,
    input  logic [ECW-1:0]  hook_ecode,
    output logic            xl_req,
    output logic [XLEN-1:0] xl_va,
    input  logic            xl_ack,
    input  logic            xl_fault,
    input  logic [ECW-1:0]  xl_code,
    input  logic [XLEN-1:0] xl_pa,
    output logic            mem_req,
    output logic [XLEN-1:0] mem_pa,
    input  logic            mem_ack,
    input  logic            mem_fault,
    input  logic [ECW-1:0]  mem_code,
    input  logic [15:0]     mem_data,
    output logic            res_valid,
    output logic [1:0]      res_kind,
    output logic [31:0]     res_instr,
    output logic [ECW-1:0]  res_code,
    output logic [XLEN-1:0] res_faddr
);
    localparam int              HW_BYTES = 2;
    localparam logic [XLEN-1:0] HW_STEP  = XLEN'(HW_BYTES);
    localparam logic [ECW-1:0]  MIS_CODE = ECW'(MISALIGN_CODE);

    hfs_state_e      st, st_nxt;
    logic [XLEN-1:0] pc_q, va_q, pa_q, pc_hi;
    logic [15:0]     lo_q;
    logic            cap_pc, cap_va, cap_pa, cap_lo;
    logic            lo_mis, hw_cmp;

    logic            ld;
    hfs_kind_e       k_d, k_q;
    logic [31:0]     ins_d;
    logic [ECW-1:0]  cd_d;
    logic [XLEN-1:0] fa_d;

    assign pc_hi = pc_q + HW_STEP;

    hfs_align_chk #(.XLEN(XLEN)) u_align (
        .addr       (hook_xaddr),
        .cmp_en     (cmp_en),
        .misaligned (lo_mis)
    );

    hfs_hw_class u_class (
        .hw     (mem_data),
        .is_cmp (hw_cmp)
    );

    hfs_result_reg #(.XLEN(XLEN), .ECW(ECW)) u_res (
        .clk     (clk),
        .rst     (rst),
        .load    (ld),
        .kind_d  (k_d),
        .instr_d (ins_d),
        .code_d  (cd_d),
        .faddr_d (fa_d),
        .kind_q  (k_q),
        .instr_q (res_instr),
        .code_q  (res_code),
        .faddr_q (res_faddr)
    );

    assign res_kind = k_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= S_IDLE;
        else     st <= st_nxt;
    end

    // datapath captures
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            va_q <= '0;
            pa_q <= '0;
            lo_q <= '0;
        end else begin
            if (cap_pc) pc_q <= req_pc;
            if (cap_va) va_q <= hook_xaddr;
            if (cap_pa) pa_q <= xl_pa;
            if (cap_lo) lo_q <= mem_data;
        end
    end

    // next state and outputs
    always_comb begin
        st_nxt     = st;
        ld         = 1'b0;
        k_d        = RK_FERR;
        ins_d      = '0;
        cd_d       = '0;
        fa_d       = pc_q;
        cap_pc     = 1'b0;
        cap_va     = 1'b0;
        cap_pa     = 1'b0;
        cap_lo     = 1'b0;
        req_ready  = 1'b0;
        hook_valid = 1'b0;
        hook_va    = pc_hi;
        xl_req     = 1'b0;
        xl_va      = va_q;
        mem_req    = 1'b0;
        mem_pa     = pa_q;
        res_valid  = 1'b0;
        unique case (st)
            S_IDLE: begin
                req_ready = 1'b1;
                hook_va   = req_pc;
                if (req_valid) begin
                    hook_valid = 1'b1;
                    cap_pc     = 1'b1;
                    if (!hook_ok) begin
                        ld     = 1'b1;
                        k_d    = RK_XERR;
                        cd_d   = hook_ecode;
                        fa_d   = req_pc;
                        st_nxt = S_DONE;
                    end else if (lo_mis) begin
                        ld     = 1'b1;
                        k_d    = RK_FERR;
                        cd_d   = MIS_CODE;
                        fa_d   = req_pc;
                        st_nxt = S_DONE;
                    end else begin
                        cap_va = 1'b1;
                        st_nxt = S_XLATE_LO;
                    end
                end
            end
            S_XLATE_LO: begin
                xl_req = 1'b1;
                if (xl_ack) begin
                    if (xl_fault) begin
                        ld     = 1'b1;
                        cd_d   = xl_code;
                        st_nxt = S_DONE;
                    end else begin
                        cap_pa = 1'b1;
                        st_nxt = S_READ_LO;
                    end
                end
            end
            S_READ_LO: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    if (mem_fault) begin
                        ld     = 1'b1;
                        cd_d   = mem_code;
                        st_nxt = S_DONE;
                    end else if (hw_cmp) begin
                        ld     = 1'b1;
                        k_d    = RK_COMP;
                        ins_d  = {16'h0000, mem_data};
                        st_nxt = S_DONE;
                    end else begin
                        hook_valid = 1'b1;
                        cap_lo     = 1'b1;
                        if (!hook_ok) begin
                            ld     = 1'b1;
                            k_d    = RK_XERR;
                            cd_d   = hook_ecode;
                            fa_d   = pc_hi;
                            st_nxt = S_DONE;
                        end else begin
                            cap_va = 1'b1;
                            st_nxt = S_XLATE_HI;
                        end
                    end
                end
            end
            S_XLATE_HI: begin
                xl_req = 1'b1;
                if (xl_ack) begin
                    if (xl_fault) begin
                        ld     = 1'b1;
                        cd_d   = xl_code;
                        fa_d   = pc_hi;
                        st_nxt = S_DONE;
                    end else begin
                        cap_pa = 1'b1;
                        st_nxt = S_READ_HI;
                    end
                end
            end
            S_READ_HI: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    ld = 1'b1;
                    if (mem_fault) begin
                        cd_d = mem_code;
                        fa_d = pc_hi;
                    end else begin
                        k_d   = RK_FULL;
                        ins_d = {mem_data, lo_q};
                    end
                    st_nxt = S_DONE;
                end
            end
            S_DONE: begin
                res_valid = 1'b1;
                st_nxt    = S_IDLE;
            end
            default: st_nxt = S_IDLE;
        endcase
    end
endmodule

// File: rtl/hfs_chk.sv
module hfs_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            req_ready,
    input logic            xl_req,
    input logic            xl_ack,
    input logic [XLEN-1:0] xl_va,
    input logic            mem_req,
    input logic            mem_ack,
    input logic [XLEN-1:0] mem_pa,
    input logic            res_valid,
    input logic [1:0]      res_kind,
    input logic [31:0]     res_instr
);
    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !res_valid && !xl_req && !mem_req));

    // R10
    res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R10
    ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && res_valid));

    // R10
    back_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> req_ready);

    // R9
    port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(xl_req && mem_req));

    // R9
    xl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xl_req && !xl_ack) |=> (xl_req && $stable(xl_va)));

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_pa)));

    // R2
    comp_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind == 2'd0) |-> (res_instr[1:0] != 2'b11 && res_instr[31:16] == 16'h0000));

    // R3
    full_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind == 2'd1) |-> (res_instr[1:0] == 2'b11));
endmodule

bind halfword_fetch_seq hfs_chk #(.XLEN(XLEN)) u_hfs_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .xl_req    (xl_req),
    .xl_ack    (xl_ack),
    .xl_va     (xl_va),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_pa    (mem_pa),
    .res_valid (res_valid),
    .res_kind  (res_kind),
    .res_instr (res_instr)
);

// File: tb/halfword_fetch_seq_bench.sv
module halfword_fetch_seq_bench;
    localparam int XLEN = 32;
    localparam int ECW  = 6;
    localparam logic [ECW-1:0]  HOOK_EC = 6'h15;
    localparam logic [ECW-1:0]  XL_EC   = 6'h0C;
    localparam logic [ECW-1:0]  MEM_EC  = 6'h01;
    localparam logic [XLEN-1:0] PA_OFS  = 32'h1000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic            cmp_en, req_valid, req_ready;
    logic [XLEN-1:0] req_pc;
    logic            hook_valid, hook_ok;
    logic [XLEN-1:0] hook_va, hook_xaddr;
    logic [ECW-1:0]  hook_ecode;
    logic            xl_req, xl_ack, xl_fault;
    logic [XLEN-1:0] xl_va, xl_pa;
    logic [ECW-1:0]  xl_code;
    logic            mem_req, mem_ack, mem_fault;
    logic [XLEN-1:0] mem_pa;
    logic [ECW-1:0]  mem_code;
    logic [15:0]     mem_data;
    logic            res_valid;
    logic [1:0]      res_kind;
    logic [31:0]     res_instr;
    logic [ECW-1:0]  res_code;
    logic [XLEN-1:0] res_faddr;

    // scenario controls
    logic [XLEN-1:0] cur_pc, xmask;
    logic            rej_lo, rej_hi, xf_lo, xf_hi, mf_lo, mf_hi;
    logic [15:0]     lo_val, hi_val;
    logic [XLEN-1:0] lo_va, hi_va;

    int n_cmp  = 0;
    int n_bad  = 0;
    int n_xl   = 0;
    int n_mem  = 0;
    int n_hook = 0;

    halfword_fetch_seq #(.XLEN(XLEN), .ECW(ECW)) u_halfword_fetch_seq (
        .clk(clk), .rst(rst), .cmp_en(cmp_en),
        .req_valid(req_valid), .req_pc(req_pc), .req_ready(req_ready),
        .hook_valid(hook_valid), .hook_va(hook_va), .hook_ok(hook_ok),
        .hook_xaddr(hook_xaddr), .hook_ecode(hook_ecode),
        .xl_req(xl_req), .xl_va(xl_va), .xl_ack(xl_ack), .xl_fault(xl_fault),
        .xl_code(xl_code), .xl_pa(xl_pa),
        .mem_req(mem_req), .mem_pa(mem_pa), .mem_ack(mem_ack), .mem_fault(mem_fault),
        .mem_code(mem_code), .mem_data(mem_data),
        .res_valid(res_valid), .res_kind(res_kind), .res_instr(res_instr),
        .res_code(res_code), .res_faddr(res_faddr)
    );

    // environment models
    always_comb begin
        lo_va      = cur_pc ^ xmask;
        hi_va      = (cur_pc + 32'd2) ^ xmask;
        hook_ok    = !((rej_lo && hook_va == cur_pc) || (rej_hi && hook_va == cur_pc + 32'd2));
        hook_xaddr = hook_va ^ xmask;
        hook_ecode = HOOK_EC;
        xl_fault   = (xf_lo && xl_va == lo_va) || (xf_hi && xl_va == hi_va);
        xl_pa      = xl_va + PA_OFS;
        xl_code    = XL_EC;
        mem_fault  = (mf_lo && mem_pa == lo_va + PA_OFS) || (mf_hi && mem_pa == hi_va + PA_OFS);
        mem_data   = (mem_pa == lo_va + PA_OFS) ? lo_val : hi_val;
        mem_code   = MEM_EC;
    end

    always @(posedge clk) begin
        if (rst) begin
            xl_ack  <= 1'b0;
            mem_ack <= 1'b0;
        end else begin
            xl_ack  <= xl_req && !xl_ack;
            mem_ack <= mem_req && !mem_ack;
            if (xl_req && xl_ack)   n_xl   <= n_xl + 1;
            if (mem_req && mem_ack) n_mem  <= n_mem + 1;
            if (hook_valid)         n_hook <= n_hook + 1;
        end
    end

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic run_one(input logic [XLEN-1:0] pc, input logic ce, input logic [XLEN-1:0] xm,
                           input int fsel, input logic [15:0] lv, input logic [15:0] hv);
        logic [1:0]      ek;
        logic [31:0]     ei;
        logic [ECW-1:0]  ec;
        logic [XLEN-1:0] ef;
        int              exl, emem, ehook, sxl, smem, shook, wait_n;
        logic [XLEN-1:0] tva;
        @(negedge clk);
        cur_pc = pc; cmp_en = ce; xmask = xm; lo_val = lv; hi_val = hv;
        rej_lo = (fsel == 1); xf_lo = (fsel == 2); mf_lo = (fsel == 3);
        rej_hi = (fsel == 4); xf_hi = (fsel == 5); mf_hi = (fsel == 6);
        sxl = n_xl; smem = n_mem; shook = n_hook;
        req_pc = pc; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_n = 0;
        while (!res_valid && wait_n < 40) begin
            @(negedge clk);
            wait_n++;
        end
        check("R10 result arrives", {63'd0, res_valid}, 64'd1);
        // expected, from the requirements
        tva = pc ^ xm;
        ei = 32'd0; ec = '0; ef = pc; exl = 0; emem = 0; ehook = 1;
        if (rej_lo) begin ek = 2'd3; ec = HOOK_EC; end                     // R4
        else if (tva[0] || (tva[1] && !ce)) begin ek = 2'd2; ec = '0; end  // R6
        else if (xf_lo) begin ek = 2'd2; ec = XL_EC; exl = 1; end          // R7
        else if (mf_lo) begin ek = 2'd2; ec = MEM_EC; exl = 1; emem = 1; end
        else if (lv[1:0] != 2'b11) begin ek = 2'd0; ei = {16'd0, lv}; exl = 1; emem = 1; end // R2
        else if (rej_hi) begin ek = 2'd3; ec = HOOK_EC; ef = pc + 32'd2; exl = 1; emem = 1; ehook = 2; end // R8
        else if (xf_hi) begin ek = 2'd2; ec = XL_EC; ef = pc + 32'd2; exl = 2; emem = 1; ehook = 2; end
        else if (mf_hi) begin ek = 2'd2; ec = MEM_EC; ef = pc + 32'd2; exl = 2; emem = 2; ehook = 2; end
        else begin ek = 2'd1; ei = {hv, lv}; exl = 2; emem = 2; ehook = 2; end // R3
        check("R2/R3/R4/R6/R7/R8 kind", {62'd0, res_kind}, {62'd0, ek});
        check("R2/R3 instr", {32'd0, res_instr}, {32'd0, ei});
        check("R4/R6/R7/R8 code", {58'd0, res_code}, {58'd0, ec});
        check("R5/R8 fault address", {32'd0, res_faddr}, {32'd0, ef});
        check("R5 translations", 64'(n_xl - sxl), 64'(exl));
        check("R2 memory reads", 64'(n_mem - smem), 64'(emem));
        check("R8 hook uses", 64'(n_hook - shook), 64'(ehook));
        @(negedge clk);
        check("R10 pulse ends", {63'd0, res_valid}, 64'd0);
        check("R10 ready again", {63'd0, req_ready}, 64'd1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        logic [XLEN-1:0] xm;
        cmp_en = 1'b1; req_valid = 1'b0; req_pc = '0; cur_pc = 32'h100; xmask = '0;
        rej_lo = 0; rej_hi = 0; xf_lo = 0; xf_hi = 0; mf_lo = 0; mf_hi = 0;
        lo_val = 16'h0; hi_val = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 req_ready", {63'd0, req_ready}, 64'd1);
        check("R1 res_valid", {63'd0, res_valid}, 64'd0);
        check("R1 xl_req", {63'd0, xl_req}, 64'd0);
        check("R1 mem_req", {63'd0, mem_req}, 64'd0);
        for (int pcl = 0; pcl < 4; pcl++)
            for (int ce = 0; ce < 2; ce++)
                for (int xi = 0; xi < 3; xi++)
                    for (int cmp = 0; cmp < 2; cmp++)
                        for (int fs = 0; fs < 7; fs++) begin
                            xm = (xi == 0) ? 32'h0 : ((xi == 1) ? 32'h1 : 32'h2);
                            run_one(32'h0000_4000 + 32'(pcl) + 32'(fs * 64 + cmp * 16),
                                    ce[0], xm, fs,
                                    {4'(pcl + fs), 10'h2A5, (cmp != 0) ? 2'b01 : 2'b11},
                                    16'hC3E0 ^ 16'(pcl * 7 + fs));
                        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule